// File: doc/BRIEF.md
# Pipelined converter decision aligner and overlap corrector

This block sits behind an eleven-stage pipelined quantizer and turns its raw stage decisions into finished 12-bit sample words. It runs on the sub-clock, which ticks twice per external convert period. Each stage hands over a 2-bit decision one sub-clock tick after the stage before it, so one sample's decisions are spread over eleven consecutive ticks. Each stage code passes through its own delay line, and the lines are sized so that all eleven codes of one sample meet in the same cycle.

Once aligned, the codes are added with each stage weighted at half of the weight of the stage before it. The 2-bit codes therefore overlap by one bit, and a decision that is off by one in an early stage is absorbed by the later stages. The sum is clamped to the 12-bit range, so an overrange input never wraps. The word is then presented either in offset binary or, with the top bit flipped, in two's complement. A float request models the high-impedance output state with flags instead of tri-state drivers.

The sample stream is valid-only. There is no ready signal, because a running quantizer cannot be stalled, so the block accepts a sample on every tick and never applies back-pressure.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While `rst_n` is low, `dout_valid` is 0, `dout_drive` is 0 and `dout` is 0. No word appears until a sample is launched after reset.
- R2: A sample is launched by `smp_valid` together with its stage-1 code. The code of stage i (1..11) is taken from `stage_codes[2i-1:2i-2]` exactly i-1 ticks after the launch. The sample's word appears after the 13th rising edge, counting the launch edge as the first (6.5 convert periods).
- R3: The result is the sum over stages of code(i) x 2^(11-i). Stage 1 weighs 1024 and stage 11 weighs 1.
- R4: For an ideal sample code X, replace one decision in any stage 1..10 by its neighbour (plus or minus one), while keeping the remainder that is left for the later stages between 0 and 3 x (stage weight - 1). The word is still X.
- R5: A sum above 4095 gives 4095 (all ones). A sum of 4095 or below passes unchanged.
- R6: With `msb_inv` low the word is offset binary: full positive scale gives 0xFFF, full negative scale gives 0x000, and bipolar zero gives 0x800. With `msb_inv` high only bit 11 is inverted, so bipolar zero gives 0x000.
- R7: `msb_inv` and `out_float` take effect at the edge on which a word enters the output register. That edge is the last of its 13, and the values present at it decide the word.
- R8: When `out_float` is sampled high, the next output has `dout_drive` = 0, `dout_valid` = 0 and `dout` = 0. The word in flight on that edge is dropped.
- R9: `dout_valid` is high for exactly one cycle per launched sample that is not floated. Launches on back-to-back ticks are accepted without loss, and ticks without a launch produce no word.
- R10: `dout` is 0 in every cycle in which `dout_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock, two ticks per convert period |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Launch marker, arrives with a sample's stage-1 code |
| stage_codes | input | 22 | Current decision of every stage, stage i in bits [2i-1:2i-2] |
| msb_inv | input | 1 | 1 selects two's-complement output coding |
| out_float | input | 1 | 1 requests the high-impedance output state |
| dout | output | 12 | Corrected sample word |
| dout_valid | output | 1 | `dout` holds a corrected sample this cycle |
| dout_drive | output | 1 | Outputs are driven (0 models high impedance) |

## Verification
The coding select and the float request are sampled on the same edge that retires a word, so a change of either can coincide with a word leaving the pipeline. To provoke this, the bench streams samples on every tick while it toggles `msb_inv` on an irregular cadence and opens and closes a float window in the middle of a stream. Each word is judged against the select and float values that the bench drove for that word's final edge, not for its launch edge. A second coincidence also occurs: an injected decision error and saturation can meet in the same word. The bench therefore sweeps every 12-bit code with a decision error placed in a rotating stage, and then drives raw code patterns that sit just below, on and above the clamp limit.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  localparam int CODE_W = 2;
  localparam int DEF_NSTAGE = 11;
endpackage

// File: rtl/corr_align.sv
module corr_align
  import adc_corr_pkg::*;
#(
  parameter int NSTAGE = DEF_NSTAGE
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NSTAGE-1:0][CODE_W-1:0]     codes_in,
  output logic [NSTAGE-1:0][CODE_W-1:0]     codes_out
);
  // Stage s+1 arrives s ticks after launch; it is delayed NSTAGE-s ticks
  // so that every stage of one sample is aligned NSTAGE-1 edges after launch.
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int DEPTH = NSTAGE - s;
    logic [DEPTH-1:0][CODE_W-1:0] line;
    always_ff @(posedge clk) begin
      line[0] <= codes_in[s];
      for (int k = 1; k < DEPTH; k++) line[k] <= line[k-1];
    end
    assign codes_out[s] = line[DEPTH-1];
  end

  a_r2_last_stage_tick: assert property (@(posedge clk) disable iff (!rst_n)
    codes_out[NSTAGE-1] == $past(codes_in[NSTAGE-1]));
endmodule

// File: rtl/corr_sum.sv
module corr_sum
  import adc_corr_pkg::*;
#(
  parameter int NSTAGE = DEF_NSTAGE,
  localparam int OUT_W = NSTAGE + 1,
  localparam int SUM_W = NSTAGE + CODE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vld_in,
  input  logic [NSTAGE-1:0][CODE_W-1:0] codes,
  output logic                          vld_q,
  output logic [OUT_W-1:0]              word_q
);
  localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << OUT_W) - 1);

  logic [SUM_W-1:0] raw;
  logic [OUT_W-1:0] clamped;

  always_comb begin
    raw = '0;
    for (int s = 0; s < NSTAGE; s++)
      raw = raw + (SUM_W'(codes[s]) << (NSTAGE - 1 - s));
  end

  assign clamped = (raw > MAXV) ? {OUT_W{1'b1}} : raw[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_in;

  always_ff @(posedge clk) word_q <= clamped;

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && (raw > MAXV)) |=> (word_q == {OUT_W{1'b1}}));
endmodule

// File: rtl/corr_fmt.sv
module corr_fmt #(
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_in,
  input  logic [OUT_W-1:0] word_in,
  input  logic             msb_inv,
  input  logic             out_float,
  output logic [OUT_W-1:0] dout,
  output logic             dout_valid,
  output logic             dout_drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
      dout_drive <= 1'b0;
    end else begin
      dout_drive <= !out_float;
      if (vld_in && !out_float) begin
        dout       <= {word_in[OUT_W-1] ^ msb_inv, word_in[OUT_W-2:0]};
        dout_valid <= 1'b1;
      end else begin
        dout       <= '0;
        dout_valid <= 1'b0;
      end
    end
  end

  a_r8_float: assert property (@(posedge clk) disable iff (!rst_n)
    out_float |=> (!dout_valid && !dout_drive && dout == '0));
  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && !out_float) |=> (dout_valid && dout[OUT_W-2:0] == $past(word_in[OUT_W-2:0])));
  a_r7_msb_select: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && !out_float) |=> (dout[OUT_W-1] == ($past(word_in[OUT_W-1]) ^ $past(msb_inv))));
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0));
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import adc_corr_pkg::*;
#(
  parameter int NSTAGE = DEF_NSTAGE,
  localparam int OUT_W = NSTAGE + 1,
  localparam int IN_W = NSTAGE * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [IN_W-1:0]  stage_codes,
  input  logic             msb_inv,
  input  logic             out_float,
  output logic [OUT_W-1:0] dout,
  output logic             dout_valid,
  output logic             dout_drive
);
  logic [NSTAGE-1:0][CODE_W-1:0] codes_now, codes_aligned;
  logic [NSTAGE-1:0]             vshift;
  logic                          sum_vld;
  logic [OUT_W-1:0]              sum_word;

  assign codes_now = stage_codes;

  // Launch marker travels with the stage-1 code.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vshift <= '0;
    else        vshift <= {vshift[NSTAGE-2:0], smp_valid};

  corr_align #(.NSTAGE(NSTAGE)) u_align (
    .clk(clk), .rst_n(rst_n), .codes_in(codes_now), .codes_out(codes_aligned)
  );

  corr_sum #(.NSTAGE(NSTAGE)) u_sum (
    .clk(clk), .rst_n(rst_n), .vld_in(vshift[NSTAGE-1]), .codes(codes_aligned),
    .vld_q(sum_vld), .word_q(sum_word)
  );

  corr_fmt #(.OUT_W(OUT_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .vld_in(sum_vld), .word_in(sum_word),
    .msb_inv(msb_inv), .out_float(out_float),
    .dout(dout), .dout_valid(dout_valid), .dout_drive(dout_drive)
  );

  a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_vld |=> !dout_valid);
endmodule

// File: tb/pipe_adc_corrector_test.sv
module pipe_adc_corrector_test;
  localparam int NST = 11;
  localparam int LAT = 12; // edges after the launch edge

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [2*NST-1:0] stage_codes = '0;
  logic msb_inv = 1'b0;
  logic out_float = 1'b0;
  logic [NST:0] dout;
  logic dout_valid, dout_drive;

  always #5 clk = ~clk;

  pipe_adc_corrector uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .stage_codes(stage_codes),
    .msb_inv(msb_inv), .out_float(out_float),
    .dout(dout), .dout_valid(dout_valid), .dout_drive(dout_drive)
  );

  int errors = 0;
  int checks = 0;
  int tick_n = 0;
  bit done = 0;

  logic [2*NST-1:0] cmem [16];
  bit    vq [32];
  int    ex [32];
  string tagq [32];
  bit    msb_at [32];
  bit    hz_at [32];

  function automatic int sumc(logic [2*NST-1:0] cv);
    int s = 0;
    for (int i = 1; i <= NST; i++) s += int'(cv[2*(i-1) +: 2]) << (NST - i);
    return (s > 4095) ? 4095 : s;
  endfunction

  // Ideal stage decisions for code x, with an optional +/-1 error at stage es.
  function automatic logic [2*NST-1:0] enc(int x, int es, int ed);
    logic [2*NST-1:0] cv = '0;
    int r = x;
    for (int i = 1; i <= NST; i++) begin
      int w = 1 << (NST - i);
      int c = r / w;
      if (c > 3) c = 3;
      if (i == es && i < NST) begin
        int cand = c + ed;
        if (cand >= 0 && cand <= 3 && r - cand*w >= 0 && r - cand*w <= 3*(w-1)) c = cand;
        else begin
          cand = c - ed;
          if (cand >= 0 && cand <= 3 && r - cand*w >= 0 && r - cand*w <= 3*(w-1)) c = cand;
        end
      end
      cv[2*(i-1) +: 2] = 2'(c);
      r -= c * w;
    end
    return cv;
  endfunction

  task automatic tick(input bit v, input logic [2*NST-1:0] cv, input int expv,
                      input string tag, input bit msb, input bit hz);
    int e, s;
    bit vx, dx;
    int dexp;
    string t;
    e = tick_n;
    vq[e%32] = v; ex[e%32] = expv; tagq[e%32] = tag;
    msb_at[e%32] = msb; hz_at[e%32] = hz;
    cmem[e%16] = v ? cv : '0;
    smp_valid = v; msb_inv = msb; out_float = hz;
    for (int i = 1; i <= NST; i++) begin
      int src = e - (i - 1);
      stage_codes[2*(i-1) +: 2] = (src >= 0) ? cmem[src%16][2*(i-1) +: 2] : 2'b00;
    end
    @(negedge clk);
    s = e - LAT;
    vx = (s >= 0) && vq[s%32] && !hz;
    dexp = vx ? (ex[s%32] ^ (msb ? 2048 : 0)) : 0;
    dx = !hz;
    if (hz) t = "R8";
    else if (vx) t = tagq[s%32];
    else if (s >= 0) t = "R9";
    else t = "R10";
    checks++;
    if (dout_valid !== vx || dout !== 12'(dexp) || dout_drive !== dx) begin
      errors++;
      $display("FAIL %s tick %0d: valid=%0b dout=%03h drive=%0b, expected valid=%0b dout=%03h drive=%0b",
               t, e, dout_valid, dout, dout_drive, vx, 12'(dexp), dx);
    end
    tick_n++;
  endtask

  task automatic idle(input int n, input bit msb, input bit hz);
    for (int k = 0; k < n; k++) tick(1'b0, '0, 0, "R9", msb, hz);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) vq[k] = 0;
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (dout_valid !== 1'b0 || dout !== '0 || dout_drive !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: valid=%0b dout=%03h drive=%0b, expected 0 000 0",
                 dout_valid, dout, dout_drive);
      end
    end
    rst_n = 1'b1;
    idle(14, 1'b0, 1'b0);

    // R2: isolated sample, exact latency
    tick(1'b1, enc(1234, 0, 0), 1234, "R2", 1'b0, 1'b0);
    idle(14, 1'b0, 1'b0);

    // R3 / R4: sweep every code, decision error in a rotating stage
    for (int x = 0; x < 4096; x++) begin
      int es = (x % 7 == 0) ? 0 : (x % 10) + 1;
      int ed = x[4] ? 1 : -1;
      tick(1'b1, enc(x, es, ed), x, (es == 0) ? "R3" : "R4", 1'b0, 1'b0);
      idle(1, 1'b0, 1'b0);
    end
    idle(13, 1'b0, 1'b0);

    // R7: back-to-back stream, coding select toggling under it
    for (int k = 0; k < 300; k++) begin
      int x = (k * 1371) % 4096;
      tick(1'b1, enc(x, (k % 10) + 1, 1), x, "R7", (k % 3 == 0) || (k % 7 == 2), 1'b0);
    end
    idle(13, 1'b0, 1'b0);

    // R6: fixed codings, select held over the flight
    tick(1'b1, enc(2048, 0, 0), 2048, "R6", 1'b0, 1'b0); idle(13, 1'b0, 1'b0);
    tick(1'b1, enc(2048, 0, 0), 2048, "R6", 1'b1, 1'b0); idle(13, 1'b1, 1'b0);
    tick(1'b1, enc(4095, 0, 0), 4095, "R6", 1'b0, 1'b0);
    tick(1'b1, enc(0, 0, 0), 0, "R6", 1'b0, 1'b0);
    tick(1'b1, enc(4095, 0, 0), 4095, "R6", 1'b1, 1'b0);
    tick(1'b1, enc(0, 0, 0), 0, "R6", 1'b1, 1'b0);
    idle(13, 1'b1, 1'b0);

    // R5: clamp boundary with raw code patterns
    begin
      logic [2*NST-1:0] p;
      p = '1;                                   tick(1'b1, p, sumc(p), "R5", 1'b0, 1'b0);
      p = '0; p[1:0] = 2'd3; p[3:2] = 2'd3;     tick(1'b1, p, sumc(p), "R5", 1'b0, 1'b0);
      p = {10{2'b01}} << 2; p[1:0] = 2'd3;       tick(1'b1, p, sumc(p), "R5", 1'b0, 1'b0);
      p = '0; p[1:0] = 2'd3; p[3:2] = 2'd2;     tick(1'b1, p, sumc(p), "R5", 1'b0, 1'b0);
      p = {10{2'b01}} << 2; p[1:0] = 2'd3; p[21:20] = 2'd0;
                                                tick(1'b1, p, sumc(p), "R5", 1'b1, 1'b0);
      p = '1;                                   tick(1'b1, p, sumc(p), "R5", 1'b1, 1'b0);
    end
    idle(13, 1'b0, 1'b0);

    // R8: float window opened and closed inside a stream
    for (int k = 0; k < 60; k++) begin
      int x = (k * 577 + 99) % 4096;
      tick(1'b1, enc(x, 0, 0), x, "R8", 1'b0, (k >= 20 && k < 35));
    end
    idle(13, 1'b0, 1'b0);

    // R9: irregular launch gaps
    for (int k = 0; k < 80; k++) begin
      int x = (k * 2333 + 7) % 4096;
      bit v = (k % 5 == 0) || (k % 5 == 1) || (k % 5 == 3);
      tick(v, enc(x, (k % 10) + 1, -1), x, "R9", 1'b0, 1'b0);
    end
    idle(14, 1'b0, 1'b0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule